// File: doc/BRIEF.md
# Threshold-Window Persistence Interrupt Unit

This block watches the stream of finished channel-0 conversion results from a light-sensing front end. Each result arrives with a one-cycle valid strobe. The block compares it against a programmable 16-bit window made of a low bound and a high bound. A result counts as a miss when it lies on or below the low bound, or strictly above the high bound.

A 4-bit persistence setting decides when misses turn into an interrupt:
- Zero means every conversion interrupts, whatever the window.
- One means a single miss is enough.
- A larger value N needs N misses in a row. Any in-window result restarts the run.

Once raised, the active-low interrupt line stays low until software pulses a clear. A new qualifying conversion in that same cycle wins over the clear. Each bound is loaded one byte at a time through byte-write strobes. Disabling interrupts holds the line high, but the run of misses is still tracked.

Top module: `thr_persist_irq`

## Requirements
- R1: After reset `irq_n` is 1 and both bounds are 0. With the reset bounds, every result is a miss, because a value of 0 is on the low bound and any other value is above the high bound.
- R2: A result is a miss when it is less than or equal to the low bound, or greater than the high bound. A result equal to the high bound is in-window.
- R3: With persistence 0, every valid result asserts the interrupt, even an in-window one.
- R4: With persistence 1, a single miss asserts the interrupt.
- R5: With persistence N (2 to 15), the interrupt asserts on the Nth consecutive miss and not before. An in-window result sets the run back to zero.
- R6: The interrupt becomes visible on `irq_n` in the cycle after the clock edge that samples the valid result. It stays low through later results until a clear pulse. `irq_n` reads 1 in the cycle after the clear.
- R7: When a clear pulse and a result that asserts the interrupt share a cycle, `irq_n` stays 0.
- R8: While `irq_en` is 0, `irq_n` is 1 from the next cycle on and nothing is latched. Misses seen while disabled still count toward the persistence run.
- R9: `thr_lo_we[0]` and `thr_hi_we[0]` load `thr_wdata` into bits 7:0 of their bound. Bit 1 of each strobe loads bits 15:8. A byte whose strobe is low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| result_valid | input | 1 | One-cycle strobe: a conversion finished |
| result_data | input | DATA_W | Channel-0 conversion result |
| thr_wdata | input | 8 | Byte to load into a bound |
| thr_lo_we | input | DATA_W/8 | Per-byte write strobes for the low bound |
| thr_hi_we | input | DATA_W/8 | Per-byte write strobes for the high bound |
| persist | input | PERSIST_W | Persistence setting |
| irq_en | input | 1 | Interrupt enable |
| irq_clear | input | 1 | Write-one clear pulse |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two functions of this block can fall in the same cycle: a software clear and a conversion that asserts the interrupt. The bench provokes this by holding `irq_clear` high in the very cycle that carries the result that completes a run of misses. It then judges from `irq_n` in the following cycle, which must stay low. A second case pairs a clear with an in-window result that does not fire. It confirms the clear still takes effect when nothing competes with it.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;
  localparam int unsigned CALC_W = 32;

  // true when the value lies on/below the low bound or strictly above the high bound
  function automatic logic outside_window(input logic [CALC_W-1:0] value,
                                          input logic [CALC_W-1:0] lo_bound,
                                          input logic [CALC_W-1:0] hi_bound);
    return (value <= lo_bound) || (value > hi_bound);
  endfunction

  // persistence rule: zero fires on every sample, otherwise the run must reach it
  function automatic logic persist_reached(input logic [CALC_W-1:0] run_len,
                                           input logic [CALC_W-1:0] setting,
                                           input logic is_miss);
    if (setting == '0) return 1'b1;
    return is_miss && (run_len >= setting);
  endfunction
endpackage

// File: rtl/thr_irq_thresh_bank.sv
module thr_irq_thresh_bank #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           wdata,
  input  logic [DATA_W/8-1:0]  byte_we,
  output logic [DATA_W-1:0]    bound
);
  localparam int unsigned NB = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          byte_q <= '0;
      else if (byte_we[b]) byte_q <= wdata;
    end
    assign bound[b*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/thr_irq_window_cmp.sv
module thr_irq_window_cmp
  import thr_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              sample,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo_bound,
  input  logic [DATA_W-1:0] hi_bound,
  output logic              miss,
  output logic              in_window
);
  logic outside;
  always_comb begin
    outside   = outside_window(CALC_W'(value), CALC_W'(lo_bound), CALC_W'(hi_bound));
    miss      = sample && outside;
    in_window = sample && !outside;
  end
endmodule

// File: rtl/thr_irq_persist_ctr.sv
module thr_irq_persist_ctr
  import thr_irq_pkg::*;
#(
  parameter int unsigned PERSIST_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample,
  input  logic                 miss,
  input  logic [PERSIST_W-1:0] persist,
  output logic [PERSIST_W-1:0] run_cnt,
  output logic                 fire
);
  localparam logic [PERSIST_W-1:0] RUN_MAX = '1;

  logic [PERSIST_W-1:0] run_next;

  always_comb begin
    run_next = run_cnt;
    if (sample) begin
      if (!miss)                run_next = '0;
      else if (run_cnt != RUN_MAX) run_next = run_cnt + 1'b1;
    end
    fire = sample && persist_reached(CALC_W'(run_next), CALC_W'(persist), miss);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= run_next;
  end
endmodule

// File: rtl/thr_irq_latch.sv
module thr_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fire,
  input  logic clear,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (!enable) pending <= 1'b0;
    else if (fire)    pending <= 1'b1;
    else if (clear)   pending <= 1'b0;
  end
endmodule

// File: rtl/thr_persist_irq.sv
module thr_persist_irq #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PERSIST_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 result_valid,
  input  logic [DATA_W-1:0]    result_data,
  input  logic [7:0]           thr_wdata,
  input  logic [DATA_W/8-1:0]  thr_lo_we,
  input  logic [DATA_W/8-1:0]  thr_hi_we,
  input  logic [PERSIST_W-1:0] persist,
  input  logic                 irq_en,
  input  logic                 irq_clear,
  output logic                 irq_n
);
  logic [DATA_W-1:0]    lo_bound;
  logic [DATA_W-1:0]    hi_bound;
  logic                 miss_evt;
  logic                 in_window;
  logic [PERSIST_W-1:0] run_cnt;
  logic                 fire_evt;
  logic                 pending;

  thr_irq_thresh_bank #(.DATA_W(DATA_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .wdata(thr_wdata), .byte_we(thr_lo_we), .bound(lo_bound));

  thr_irq_thresh_bank #(.DATA_W(DATA_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .wdata(thr_wdata), .byte_we(thr_hi_we), .bound(hi_bound));

  thr_irq_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample(result_valid), .value(result_data), .lo_bound(lo_bound), .hi_bound(hi_bound),
    .miss(miss_evt), .in_window(in_window));

  thr_irq_persist_ctr #(.PERSIST_W(PERSIST_W)) u_run (
    .clk(clk), .rst_n(rst_n), .sample(result_valid), .miss(miss_evt), .persist(persist),
    .run_cnt(run_cnt), .fire(fire_evt));

  thr_irq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .enable(irq_en), .fire(fire_evt), .clear(irq_clear),
    .pending(pending));

  assign irq_n = ~pending;
endmodule

// File: rtl/thr_persist_irq_chk.sv
module thr_persist_irq_chk #(
  parameter int unsigned PERSIST_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 result_valid,
  input logic [PERSIST_W-1:0] persist,
  input logic                 irq_en,
  input logic                 irq_clear,
  input logic                 irq_n,
  input logic                 fire_evt,
  input logic                 in_window,
  input logic [PERSIST_W-1:0] run_cnt
);
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> irq_n);

  p_latched_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_clear && irq_en) |=> !irq_n);

  p_clear_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !fire_evt) |=> irq_n);

  p_fire_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_evt && irq_en) |=> !irq_n);

  p_inwin_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |=> (run_cnt == '0));

  p_every_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && persist == '0 && irq_en) |=> !irq_n);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !result_valid) |=> irq_n);
endmodule

bind thr_persist_irq thr_persist_irq_chk #(.PERSIST_W(PERSIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .result_valid(result_valid), .persist(persist),
  .irq_en(irq_en), .irq_clear(irq_clear), .irq_n(irq_n), .fire_evt(fire_evt),
  .in_window(in_window), .run_cnt(run_cnt));

// File: tb/thr_persist_irq_tb.sv
module thr_persist_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        result_valid = 1'b0;
  logic [15:0] result_data = '0;
  logic [7:0]  thr_wdata = '0;
  logic [1:0]  thr_lo_we = '0;
  logic [1:0]  thr_hi_we = '0;
  logic [3:0]  persist = '0;
  logic        irq_en = 1'b0;
  logic        irq_clear = 1'b0;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic exp_n; string tag; } exp_t;
  exp_t sb_q[$];

  // bench-side reference state
  int unsigned m_lo = 0, m_hi = 0, m_run = 0;
  bit m_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_persist_irq u_dut (
    .clk(clk), .rst_n(rst_n), .result_valid(result_valid), .result_data(result_data),
    .thr_wdata(thr_wdata), .thr_lo_we(thr_lo_we), .thr_hi_we(thr_hi_we), .persist(persist),
    .irq_en(irq_en), .irq_clear(irq_clear), .irq_n(irq_n));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq_n=%0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: a quarter period after each rising edge, compare against the queue
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(irq_n, e.exp_n, e.tag);
      end
    end
  end

  // driver: one cycle of stimulus; predicts irq_n after the next edge
  task automatic step(input bit v, input logic [15:0] val, input bit clr, input string tag);
    bit miss, fire;
    exp_t e;
    result_valid = v; result_data = val; irq_clear = clr;
    miss = v && ((val <= m_lo) || (val > m_hi));
    if (v) m_run = miss ? m_run + 1 : 0;
    fire = v && ((persist == 0) || (miss && m_run >= persist));
    if (!irq_en) m_pend = 1'b0;
    else if (fire) m_pend = 1'b1;
    else if (clr) m_pend = 1'b0;
    e.exp_n = !m_pend; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    result_valid = 1'b0; irq_clear = 1'b0;
  endtask

  task automatic wr_bound(input bit hi, input bit msb, input logic [7:0] d);
    thr_wdata = d;
    if (hi) begin
      thr_hi_we[msb] = 1'b1;
      m_hi = msb ? ((m_hi & 32'h00FF) | (d << 8)) : ((m_hi & 32'hFF00) | d);
    end else begin
      thr_lo_we[msb] = 1'b1;
      m_lo = msb ? ((m_lo & 32'h00FF) | (d << 8)) : ((m_lo & 32'hFF00) | d);
    end
    @(negedge clk);
    thr_lo_we = '0; thr_hi_we = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_n, 1'b1, "R1 reset state");

    // R1/R4: reset bounds are zero, so 0 and 5 are both misses with persist 1
    irq_en = 1'b1; persist = 4'd1;
    step(1, 16'd0, 0, "R1 zero bounds, value 0 misses (R4)");
    step(0, 16'd0, 1, "R6 clear releases");
    step(1, 16'd5, 0, "R1 zero bounds, value above high misses");
    step(0, 16'd0, 1, "R6 clear releases");

    // R9: assemble bounds lo=0x0100 hi=0x0800 byte by byte
    wr_bound(0, 1, 8'h01); wr_bound(0, 0, 8'h00);
    wr_bound(1, 0, 8'h00); wr_bound(1, 1, 8'h08);
    step(1, 16'h0100, 0, "R2 equal to low bound is a miss");
    step(0, 16'h0, 1, "R6 clear");
    step(1, 16'h0800, 0, "R2 equal to high bound is in-window");
    step(1, 16'h0801, 0, "R2 above high bound is a miss");
    step(0, 16'h0, 1, "R6 clear");
    step(1, 16'h0101, 0, "R2 just above low bound in-window");
    // R9: rewrite only the high byte of the high bound -> 0x0900
    wr_bound(1, 1, 8'h09);
    step(1, 16'h0801, 0, "R9 high byte alone updated, 0x0801 in-window");
    step(1, 16'h0901, 0, "R9 0x0901 above new bound");
    step(0, 16'h0, 1, "R6 clear");

    // R3: persist 0 fires on in-window data
    persist = 4'd0;
    step(1, 16'h0400, 0, "R3 in-window still fires");
    step(0, 16'h0, 1, "R6 clear");

    // R5: persist 3 with an in-window break
    persist = 4'd3;
    step(1, 16'h0010, 0, "R5 miss 1 of 3");
    step(1, 16'h0010, 0, "R5 miss 2 of 3");
    step(1, 16'h0400, 0, "R5 in-window restarts run");
    step(1, 16'h0010, 0, "R5 miss 1 after restart");
    step(1, 16'h0010, 0, "R5 miss 2 after restart");
    step(1, 16'h0010, 0, "R5 third consecutive miss fires");
    // R6: stays latched through in-window results
    step(1, 16'h0400, 0, "R6 held through in-window");
    step(0, 16'h0, 0, "R6 held idle");
    step(1, 16'h0400, 1, "R6 clear with non-firing result releases");

    // R7: clear in the firing cycle
    step(1, 16'h0010, 0, "R7 run 1");
    step(1, 16'h0010, 0, "R7 run 2");
    step(1, 16'h0010, 1, "R7 fire beats clear");
    step(0, 16'h0, 1, "R7 later clear releases");

    // R5 boundary: persist 15
    persist = 4'd15;
    step(1, 16'h0400, 0, "R5 restart before 15-run");
    for (int i = 1; i <= 15; i++) step(1, 16'hF000, 0, $sformatf("R5 15-run miss %0d", i));
    step(0, 16'h0, 1, "R6 clear");

    // R8: disabled, misses still counted
    persist = 4'd3;
    step(1, 16'h0400, 0, "R8 restart");
    irq_en = 1'b0;
    step(1, 16'h0010, 0, "R8 disabled miss 1 quiet");
    step(1, 16'h0010, 0, "R8 disabled miss 2 quiet");
    irq_en = 1'b1;
    step(1, 16'h0010, 0, "R8 run carried across disable fires");
    irq_en = 1'b0;
    step(0, 16'h0, 0, "R8 disable releases line");
    irq_en = 1'b1;
    step(0, 16'h0, 0, "R8 nothing latched while disabled");

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule